// File: doc/BRIEF.md
# One-Time-Programmable ROM Mode Decoder

This block is a cycle-level behavioural model of the control side of a word-wide one-time-programmable ROM. A small parameterised array (256 words of 16 bits by default) stands in for the full-size cell array. Two active-low controls gate the outputs. The chip select acts as the device selection. The output enable acts as the bus read strobe. Analog conditions appear as single-bit flags: one for a high programming voltage on the program supply and one for an overvoltage on the identification address line.

The block decodes several operating modes: read, output disable, standby, program, program inhibit, program verify and product identification. Programming can only clear bits. Several devices can be gang-programmed by sharing every input except the chip select. Access time is modelled as latency in clock cycles. A long delay applies after an address or mode change, and a short delay applies after the output enable falls. The `rdata_oe` output stands for the tri-state enable of the data pins. While it is low, `rdata` is held at zero.

Top module: `otprom_ctl`

## Requirements
- R1: After reset every array word reads 0xFFFF and `rdata_oe` is low.
- R2: With `vpp_hi` low, `a9_hv` low and both `ce_n` and `oe_n` low, `rdata` carries the addressed word with `rdata_oe` high. Whenever `rdata_oe` is low, `rdata` is zero.
- R3: With `ce_n` low and `oe_n` high, `rdata_oe` stays low.
- R4: With `ce_n` high and `vpp_hi` low, `rdata_oe` stays low whatever `oe_n` is.
- R5: With `vpp_hi` high, `ce_n` low and `oe_n` high, each rising clock edge sets the addressed word to its old value ANDed with `wdata`, and `rdata_oe` stays low.
- R6: A bit that has been cleared is never set again, even by a later program cycle with a one in that position.
- R7: With `vpp_hi` high and both `ce_n` and `oe_n` high, the array is not changed and `rdata_oe` stays low.
- R8: With `vpp_hi` high, `ce_n` high and `oe_n` low, the stored word at `addr` is driven out.
- R9: With `a9_hv` high, `vpp_hi` low, both controls low and `addr[1]` high, the output is the manufacturer code when `addr[0]` is 0 and the device code when `addr[0]` is 1. Both codes are 8-bit parameters (defaults 0xA7 and 0x5E), zero-extended to the data width.
- R10: In identification mode with `addr[1]` low, the output is 0x007F.
- R11: Output data is valid only after ACC_LAT (default 3) rising edges with `addr`, `ce_n`, `vpp_hi` and `a9_hv` unchanged, and after OE_LAT (default 1) rising edges with `oe_n` low. Any change of those inputs turns `rdata_oe` off immediately.
- R12: With `vpp_hi` high and both controls low, the stored word is read and the array is not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; fills the array with ones |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming voltage present on the program supply |
| a9_hv | input | 1 | Overvoltage present on the identification address line |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Data to program |
| rdata | output | DATA_W | Output data, zero while not driven |
| rdata_oe | output | 1 | Output driver enable (low means high impedance) |

## Verification
The assertions assume that `ce_n`, `oe_n`, `vpp_hi`, `a9_hv` and `addr` are driven to known levels from the first clock edge and change only away from the rising edge. They also assume both latency parameters are at least one, so that the cycle in which the output enable falls or an address changes can never show valid data. The stimulus changes every input on the falling clock edge and holds it steady across each rising edge. Before each access it parks the device in standby, so every access starts from a known timer state. It never uses the identification flag together with the programming flag.

// File: rtl/otprom_ctl.sv
module otprom_ctl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int ACC_LAT = 3,
  parameter int OE_LAT = 1,
  parameter logic [7:0] MFG_ID = 8'hA7,
  parameter logic [7:0] DEV_ID = 8'h5E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW = $clog2(ACC_LAT + OE_LAT + 2);
  localparam int KW = ADDR_W + 3;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0] acc_cnt, oe_cnt;
  logic [KW-1:0] key, key_q;

  assign key = {addr, a9_hv, vpp_hi, ce_n};

  wire prog_m = vpp_hi & ~ce_n & oe_n;
  wire vrfy_m = vpp_hi & ce_n & ~oe_n;
  wire read_m = ~ce_n & ~oe_n;
  wire id_m   = read_m & a9_hv & ~vpp_hi;

  wire acc_ok = (acc_cnt >= CW'(ACC_LAT)) && (key == key_q);
  wire oe_ok  = (oe_cnt >= CW'(OE_LAT)) && !oe_n;

  wire [7:0] id_code = addr[1] ? (addr[0] ? DEV_ID : MFG_ID) : 8'h7F;
  wire [DATA_W-1:0] id_word = {{(DATA_W-8){1'b0}}, id_code};

  assign rdata_oe = (read_m | vrfy_m) & acc_ok & oe_ok;
  assign rdata = rdata_oe ? (id_m ? id_word : mem[addr]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      acc_cnt <= '0;
      oe_cnt  <= '0;
    end else begin
      key_q <= key;
      if (key != key_q)
        acc_cnt <= CW'(1);
      else if (acc_cnt < CW'(ACC_LAT))
        acc_cnt <= acc_cnt + CW'(1);
      if (oe_n)
        oe_cnt <= '0;
      else if (oe_cnt < CW'(OE_LAT))
        oe_cnt <= oe_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (prog_m) begin
      mem[addr] <= mem[addr] & wdata;
    end
  end
endmodule

module otprom_ctl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe
);
  a_r2_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0);
  a_r3_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> !rdata_oe);
  a_r4_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |-> !rdata_oe);
  a_r5_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !ce_n && oe_n) |-> !rdata_oe);
  a_r7_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && ce_n && oe_n) |-> !rdata_oe);
  a_r10_continuation: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && a9_hv && !vpp_hi && !addr[1]) |-> rdata == DATA_W'(8'h7F));
  a_r11_oe_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !rdata_oe);
  a_r11_addr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> !rdata_oe);
endmodule

bind otprom_ctl otprom_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
  .a9_hv(a9_hv), .addr(addr), .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/otprom_ctl_test.sv
module otprom_ctl_test;
  localparam int ACC = 3;
  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, vpp_hi = 0, a9_hv = 0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '1;
  logic [15:0] rdata;
  logic rdata_oe;
  logic [15:0] model [256];
  int checks = 0, errors = 0;

  otprom_ctl uut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe));

  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic oe_exp, input logic [15:0] d_exp);
    #1;
    checks++;
    if (rdata_oe !== oe_exp || rdata !== d_exp) begin
      errors++;
      $display("FAIL %s: got oe=%b data=%h, expected oe=%b data=%h",
               tag, rdata_oe, rdata, oe_exp, d_exp);
    end
  endtask

  task automatic park();
    ce_n = 1; oe_n = 1; vpp_hi = 0; a9_hv = 0;
    step(1);
  endtask

  task automatic access(input logic [7:0] a, input logic v, input logic c,
                        input logic x9, input logic [15:0] exp, input string tag);
    park();
    addr = a; vpp_hi = v; ce_n = c; oe_n = 0; a9_hv = x9;
    step(ACC - 1);
    chk({tag, " R11 early"}, 1'b0, 16'h0);
    step(1);
    chk(tag, 1'b1, exp);
  endtask

  task automatic program_word(input logic [7:0] a, input logic [15:0] d, input int n);
    park();
    addr = a; wdata = d; vpp_hi = 1; ce_n = 0; oe_n = 1;
    step(n);
    chk("R5 outputs off while programming", 1'b0, 16'h0);
    model[a] = model[a] & d;
    wdata = '1;
  endtask

  task automatic t_reset();
    chk("R1 reset outputs off", 1'b0, 16'h0);
    access(8'h00, 0, 0, 0, 16'hFFFF, "R1 word 0 erased");
    access(8'hFF, 0, 0, 0, 16'hFFFF, "R1 word 255 erased");
  endtask

  task automatic t_program();
    program_word(8'h10, 16'h1234, 1);
    access(8'h10, 0, 0, 0, model[8'h10], "R2 R5 read programmed word");
    program_word(8'h20, 16'hA5F0, 3);
    access(8'h20, 0, 0, 0, model[8'h20], "R2 R5 multi-edge program");
    access(8'h11, 0, 0, 0, 16'hFFFF, "R5 neighbour untouched");
  endtask

  task automatic t_otp();
    program_word(8'h09, 16'h00FF, 1);
    program_word(8'h09, 16'hFF0F, 1);
    access(8'h09, 0, 0, 0, 16'h000F, "R6 cleared bits stay cleared");
    program_word(8'h09, 16'hFFFF, 2);
    access(8'h09, 0, 0, 0, 16'h000F, "R6 all-ones write restores nothing");
  endtask

  task automatic t_disable_standby();
    park();
    addr = 8'h10; ce_n = 0; oe_n = 1;
    step(5);
    chk("R3 OE high disables output", 1'b0, 16'h0);
    oe_n = 0;
    chk("R11 no data in OE fall cycle", 1'b0, 16'h0);
    step(1);
    chk("R11 data one edge after OE fall", 1'b1, model[8'h10]);
    ce_n = 1;
    step(5);
    chk("R4 standby with OE low", 1'b0, 16'h0);
  endtask

  task automatic t_addr_change();
    access(8'h20, 0, 0, 0, model[8'h20], "R2 read before change");
    addr = 8'h10;
    chk("R11 addr change drops output", 1'b0, 16'h0);
    step(ACC - 1);
    chk("R11 still waiting after change", 1'b0, 16'h0);
    step(1);
    chk("R11 new word after access time", 1'b1, model[8'h10]);
  endtask

  task automatic t_inhibit_verify();
    park();
    addr = 8'h30; wdata = 16'h0000; vpp_hi = 1; ce_n = 1; oe_n = 1;
    step(4);
    chk("R7 inhibit outputs off", 1'b0, 16'h0);
    wdata = '1;
    access(8'h30, 0, 0, 0, 16'hFFFF, "R7 inhibited word unchanged");
    access(8'h20, 1, 1, 0, model[8'h20], "R8 verify reads stored word");
    access(8'h09, 1, 1, 0, 16'h000F, "R8 verify second word");
  endtask

  task automatic t_both_low_vpp();
    park();
    wdata = 16'h0000;
    access(8'h40, 1, 0, 0, 16'hFFFF, "R12 both low with vpp reads");
    wdata = '1;
    access(8'h40, 0, 0, 0, 16'hFFFF, "R12 no programming happened");
  endtask

  task automatic t_ident();
    access(8'hFE, 0, 0, 1, 16'h00A7, "R9 manufacturer code");
    access(8'hFF, 0, 0, 1, 16'h005E, "R9 device code");
    access(8'hFD, 0, 0, 1, 16'h007F, "R10 continuation code");
    access(8'hFC, 0, 0, 1, 16'h007F, "R10 continuation code a0 low");
    access(8'hFE, 0, 0, 0, 16'hFFFF, "R9 no id without overvoltage");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    step(1);
    t_reset();
    t_program();
    t_otp();
    t_disable_standby();
    t_addr_change();
    t_inhibit_verify();
    t_both_low_vpp();
    t_ident();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule